// File: doc/BRIEF.md
# Page Table Walk Setup Decoder

This block turns a translation control word, two 64-bit table base registers, a regime flag and a virtual address into the parameters a long-descriptor table walker needs before its first memory read. It decides which of the two base registers covers the address and normalizes that region's granule field to a small index (0 = 4K, 1 = 16K, 2 = 64K). It also computes the input address size, the level the walk starts at and the output address size. Any inconsistency in the setup is reported as a fault with a cause code.

Requests enter through a valid/ready pair. The decoded result is registered and presented on a second valid/ready pair. It stays stable until the consumer accepts it, and a new request can be taken in the same cycle that the old result is accepted. The narrow (32-bit) regime has its own region-split rules and can be removed by a parameter.

Control word fields used below: low-region size `[5:0]`, high-region size `[13:8]`, low granule code `[17:16]`, high granule code `[19:18]`, low disable `[20]`, high disable `[21]`, low tag-ignore `[22]`, high tag-ignore `[23]`, physical-size code `[26:24]`.

Top module: `wsd_walk_setup`

## Requirements
- R1: The low-region granule code maps 0 to index 0 (4K), 1 to index 2 (64K), 2 to index 1 (16K) and 3 to index 0.
- R2: The high-region granule code maps 1 to index 1, 3 to index 2, and 0 or 2 to index 0. In the 32-bit regime the index is always 0.
- R3: In the 64-bit regime the region bit is VA[55] when the tag-ignore flag of the half named by VA[55] is set, and VA[63] otherwise. A region bit of 1 selects the high base register (out_sel_hi = 1).
- R4: In the 64-bit regime the input size is 64 minus the selected region's size field. An input size above 48 or below 25 gives cause 1 (bad size).
- R5: In the 32-bit regime only the low 3 bits of each size field count (s0, s1). The low region matches when s0 = 0 or VA[31:32-s0] are all zero. The high region is chosen when s1 != 0 and VA[31:32-s1] are all one, or when s1 = 0 and the low region did not match. The input size is 32 minus the chosen field.
- R6: A set disable flag for the selected region gives cause 2. In the 32-bit regime, an address that matches neither region also gives cause 2, with out_sel_hi = 0 and the input size taken from s0.
- R7: When there is no fault, the start level is 4 - ceil((in_size - g)/(g - 3)), where g is 12, 14 or 16 for granule index 0, 1 or 2.
- R8: In the 64-bit regime, physical-size codes 0..5 give output sizes 32, 36, 40, 42, 44 and 48. Codes 6 and 7 give cause 1. In the 32-bit regime the output size is 40 and the code is ignored.
- R9: When the output size is below 48, any set bit of the selected base register from the output size up to bit 47 gives cause 3.
- R10: Causes rank as follows: an input-size fault first, then the disable fault, then a physical-code fault, then the base-range fault.
- R11: in_ready is high exactly when no result is held or the held result is accepted in that cycle. A held result does not change while out_ready is low.
- R12: out_fault is high exactly when out_cause is non-zero. After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_ctrl | input | 32 | Translation control word |
| in_base_lo | input | 64 | Low-region table base register |
| in_base_hi | input | 64 | High-region table base register |
| in_mode64 | input | 1 | 1 = 64-bit regime, 0 = 32-bit regime |
| in_va | input | 64 | Virtual address to translate |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer accepts the result |
| out_sel_hi | output | 1 | 1 = high base register selected |
| out_gran | output | 2 | Normalized granule index |
| out_in_size | output | 7 | Input address size in bits |
| out_level | output | 2 | Start lookup level |
| out_out_size | output | 7 | Output address size in bits |
| out_fault | output | 1 | Setup fault |
| out_cause | output | 2 | 0 none, 1 bad size, 2 region disabled, 3 base out of range |

## Verification
The four fault checks can all fire on one request, so the cause priority is the point that needs the most care. The bench drives a region disable, a reserved physical-size code and an out-of-range base bit together in every combination. It also uses region sizes that are legal and illegal, and it expects only the highest-ranked cause. The second overlap is on the handshake. A new request is offered while a result is stalled, and ready is then raised. The bench checks that the old result stays unchanged during the stall and that the new request is taken in the same cycle the old one is accepted.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

   localparam int CTRL_W   = 32;
   localparam int F_SZ_W   = 6;
   localparam int F_SZ_LO  = 0;
   localparam int F_SZ_HI  = 8;
   localparam int F_GR_LO  = 16;
   localparam int F_GR_HI  = 18;
   localparam int F_OFF_LO = 20;
   localparam int F_OFF_HI = 21;
   localparam int F_TAG_LO = 22;
   localparam int F_TAG_HI = 23;
   localparam int F_PS     = 24;
   localparam int F_PS_W   = 3;
   localparam int SIZE_W   = 7;

   typedef enum logic [1:0] {
      GR_4K  = 2'd0,
      GR_16K = 2'd1,
      GR_64K = 2'd2
   } gran_e;

   typedef enum logic [1:0] {
      FC_NONE = 2'd0,
      FC_SIZE = 2'd1,
      FC_OFF  = 2'd2,
      FC_BASE = 2'd3
   } cause_e;

   // low-region granule code: 1 -> 64K, 2 -> 16K, others -> 4K
   function automatic gran_e dec_gran_lo(input logic [1:0] code);
      case (code)
         2'd1:    return GR_64K;
         2'd2:    return GR_16K;
         default: return GR_4K;
      endcase
   endfunction

   // high-region granule code: 1 -> 16K, 3 -> 64K, others -> 4K
   function automatic gran_e dec_gran_hi(input logic [1:0] code);
      case (code)
         2'd1:    return GR_16K;
         2'd3:    return GR_64K;
         default: return GR_4K;
      endcase
   endfunction

   function automatic logic [4:0] grain_shift(input gran_e g);
      case (g)
         GR_16K:  return 5'd14;
         GR_64K:  return 5'd16;
         default: return 5'd12;
      endcase
   endfunction

   function automatic logic [SIZE_W-1:0] phys_bits(input logic [F_PS_W-1:0] code);
      case (code)
         3'd0:    return 7'd32;
         3'd1:    return 7'd36;
         3'd2:    return 7'd40;
         3'd3:    return 7'd42;
         3'd4:    return 7'd44;
         3'd5:    return 7'd48;
         3'd6:    return 7'd52;
         default: return 7'd48;
      endcase
   endfunction

endpackage

// File: rtl/wsd_region_pick.sv
module wsd_region_pick
   import wsd_pkg::*;
#(
   parameter int VA_W        = 64,
   parameter int TAG_BIT     = 55,
   parameter int NARROW_W    = 32,
   parameter int NARROW_SZ_W = 3,
   parameter bit HAS_NARROW  = 1'b1
) (
   input  logic [CTRL_W-1:0] ctrl,
   input  logic [VA_W-1:0]   va,
   input  logic              mode64,
   output logic              sel_hi,
   output gran_e             gran,
   output logic [SIZE_W-1:0] in_size,
   output logic              no_walk
);
   localparam int VA_TOP = VA_W - 1;

   logic [F_SZ_W-1:0] sz_lo, sz_hi;
   assign sz_lo = ctrl[F_SZ_LO +: F_SZ_W];
   assign sz_hi = ctrl[F_SZ_HI +: F_SZ_W];

   // wide regime
   logic              w_tag_en, w_sel, w_off;
   gran_e             w_gran;
   logic [SIZE_W-1:0] w_in;

   always_comb begin
      w_tag_en = va[TAG_BIT] ? ctrl[F_TAG_HI] : ctrl[F_TAG_LO];
      w_sel    = w_tag_en ? va[TAG_BIT] : va[VA_TOP];
      w_gran   = w_sel ? dec_gran_hi(ctrl[F_GR_HI +: 2]) : dec_gran_lo(ctrl[F_GR_LO +: 2]);
      w_in     = SIZE_W'(VA_W) - SIZE_W'(w_sel ? sz_hi : sz_lo);
      w_off    = w_sel ? ctrl[F_OFF_HI] : ctrl[F_OFF_LO];
   end

   // narrow regime
   logic              n_sel, n_off;
   logic [SIZE_W-1:0] n_in;

   generate
      if (HAS_NARROW) begin : g_narrow
         logic [NARROW_SZ_W-1:0] s0, s1;
         logic [NARROW_W-1:0]    nva;
         logic                   lo_hit, hi_hit;

         always_comb begin
            s0     = sz_lo[NARROW_SZ_W-1:0];
            s1     = sz_hi[NARROW_SZ_W-1:0];
            nva    = va[NARROW_W-1:0];
            lo_hit = (s0 == '0) || ((nva >> (NARROW_W - int'(s0))) == '0);
            hi_hit = ((s1 != '0) && (((~nva) >> (NARROW_W - int'(s1))) == '0)) ||
                     ((s1 == '0) && !lo_hit);
            n_sel  = hi_hit;
            n_in   = SIZE_W'(NARROW_W) - SIZE_W'(hi_hit ? s1 : s0);
            if (hi_hit)      n_off = ctrl[F_OFF_HI];
            else if (lo_hit) n_off = ctrl[F_OFF_LO];
            else             n_off = 1'b1;
         end
      end else begin : g_no_narrow
         assign n_sel = 1'b0;
         assign n_in  = SIZE_W'(NARROW_W);
         assign n_off = 1'b1;
      end
   endgenerate

   always_comb begin
      if (mode64) begin
         sel_hi  = w_sel;
         gran    = w_gran;
         in_size = w_in;
         no_walk = w_off;
      end else begin
         sel_hi  = n_sel;
         gran    = GR_4K;
         in_size = n_in;
         no_walk = n_off;
      end
   end

   generate
      if (TAG_BIT >= VA_W) begin : g_bad_tag
         $error("tag bit must lie inside the address");
      end
      if (NARROW_W >= VA_W || (1 << NARROW_SZ_W) > NARROW_W) begin : g_bad_narrow
         $error("narrow regime widths inconsistent");
      end
   endgenerate

endmodule

// File: rtl/wsd_level_calc.sv
module wsd_level_calc
   import wsd_pkg::*;
#(
   parameter int LEVELS = 4,
   parameter int LVL_W  = 2
) (
   input  gran_e             gran,
   input  logic [SIZE_W-1:0] in_size,
   output logic [LVL_W-1:0]  level
);
   localparam int SW  = SIZE_W + 2;
   localparam int QW  = $clog2(LEVELS + 1);

   logic signed [SW-1:0] span, stride;
   logic [LEVELS-1:0]    past;
   logic [QW-1:0]        steps;

   always_comb begin
      span   = $signed({2'b00, in_size}) - $signed(SW'(grain_shift(gran)));
      stride = $signed(SW'(grain_shift(gran))) - $signed(SW'(3));
   end

   // ceil(span/stride) for 0 < span <= LEVELS*stride counts the thresholds passed
   generate
      for (genvar k = 0; k < LEVELS; k++) begin : g_thr
         assign past[k] = span > ($signed(SW'(k)) * stride);
      end
   endgenerate

   always_comb begin
      steps = '0;
      for (int k = 0; k < LEVELS; k++) steps = steps + QW'(past[k]);
      if (steps == '0) level = LVL_W'(LEVELS - 1);
      else             level = LVL_W'(LEVELS - int'(steps));
   end

   generate
      if ((1 << LVL_W) < LEVELS) begin : g_bad_lvl
         $error("level width too small");
      end
   endgenerate

endmodule

// File: rtl/wsd_limit_check.sv
module wsd_limit_check
   import wsd_pkg::*;
#(
   parameter int VA_W        = 64,
   parameter int PA_MAX      = 48,
   parameter int MIN_IN      = 25,
   parameter int NARROW_OUT  = 40,
   parameter int PS_MAX_CODE = 5
) (
   input  logic              mode64,
   input  logic [F_PS_W-1:0] ps_code,
   input  logic [VA_W-1:0]   base,
   input  logic [SIZE_W-1:0] in_size,
   input  logic              no_walk,
   output logic [SIZE_W-1:0] out_size,
   output cause_e            cause
);
   logic              in_bad, ps_bad;
   logic [PA_MAX-1:0] over;

   assign out_size = mode64 ? phys_bits(ps_code) : SIZE_W'(NARROW_OUT);
   assign in_bad   = mode64 && ((in_size > SIZE_W'(PA_MAX)) || (in_size < SIZE_W'(MIN_IN)));
   assign ps_bad   = mode64 && (ps_code > F_PS_W'(PS_MAX_CODE));

   generate
      for (genvar i = 0; i < PA_MAX; i++) begin : g_over
         assign over[i] = base[i] && (SIZE_W'(i) >= out_size);
      end
   endgenerate

   always_comb begin
      if (in_bad)                                         cause = FC_SIZE;
      else if (no_walk)                                   cause = FC_OFF;
      else if (ps_bad)                                    cause = FC_SIZE;
      else if ((out_size < SIZE_W'(PA_MAX)) && |over)     cause = FC_BASE;
      else                                                cause = FC_NONE;
   end

   generate
      if (phys_bits(F_PS_W'(PS_MAX_CODE)) != SIZE_W'(PA_MAX)) begin : g_bad_ps
         $error("largest supported physical code must give PA_MAX");
      end
      if (PA_MAX > VA_W || MIN_IN >= PA_MAX) begin : g_bad_pa
         $error("address size limits inconsistent");
      end
   endgenerate

endmodule

// File: rtl/wsd_walk_setup.sv
module wsd_walk_setup
   import wsd_pkg::*;
#(
   parameter int VA_W        = 64,
   parameter int TAG_BIT     = 55,
   parameter int PA_MAX      = 48,
   parameter int MIN_IN      = 25,
   parameter int NARROW_W    = 32,
   parameter int NARROW_SZ_W = 3,
   parameter int NARROW_OUT  = 40,
   parameter bit HAS_NARROW  = 1'b1,
   parameter int LEVELS      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CTRL_W-1:0] in_ctrl,
   input  logic [VA_W-1:0]   in_base_lo,
   input  logic [VA_W-1:0]   in_base_hi,
   input  logic              in_mode64,
   input  logic [VA_W-1:0]   in_va,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_sel_hi,
   output logic [1:0]        out_gran,
   output logic [SIZE_W-1:0] out_in_size,
   output logic [1:0]        out_level,
   output logic [SIZE_W-1:0] out_out_size,
   output logic              out_fault,
   output logic [1:0]        out_cause
);
   localparam int LVL_W = $clog2(LEVELS);

   logic              c_sel_hi, c_no_walk;
   gran_e             c_gran;
   logic [SIZE_W-1:0] c_in_size, c_out_size;
   logic [LVL_W-1:0]  c_level;
   cause_e            c_cause;
   logic [VA_W-1:0]   c_base;

   wsd_region_pick #(
      .VA_W(VA_W), .TAG_BIT(TAG_BIT), .NARROW_W(NARROW_W),
      .NARROW_SZ_W(NARROW_SZ_W), .HAS_NARROW(HAS_NARROW)
   ) u_pick (
      .ctrl(in_ctrl), .va(in_va), .mode64(in_mode64),
      .sel_hi(c_sel_hi), .gran(c_gran), .in_size(c_in_size), .no_walk(c_no_walk)
   );

   wsd_level_calc #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_lvl (
      .gran(c_gran), .in_size(c_in_size), .level(c_level)
   );

   assign c_base = c_sel_hi ? in_base_hi : in_base_lo;

   wsd_limit_check #(
      .VA_W(VA_W), .PA_MAX(PA_MAX), .MIN_IN(MIN_IN), .NARROW_OUT(NARROW_OUT)
   ) u_lim (
      .mode64(in_mode64), .ps_code(in_ctrl[F_PS +: F_PS_W]), .base(c_base),
      .in_size(c_in_size), .no_walk(c_no_walk),
      .out_size(c_out_size), .cause(c_cause)
   );

   logic take;
   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_sel_hi   <= 1'b0;
         out_gran     <= 2'd0;
         out_in_size  <= '0;
         out_level    <= '0;
         out_out_size <= '0;
         out_fault    <= 1'b0;
         out_cause    <= 2'd0;
      end else begin
         if (take) begin
            out_valid    <= 1'b1;
            out_sel_hi   <= c_sel_hi;
            out_gran     <= c_gran;
            out_in_size  <= c_in_size;
            out_level    <= 2'(c_level);
            out_out_size <= c_out_size;
            out_fault    <= (c_cause != FC_NONE);
            out_cause    <= c_cause;
         end else if (out_ready) begin
            out_valid    <= 1'b0;
         end
      end
   end

   generate
      if (VA_W != 64 || LEVELS != 4) begin : g_bad_top
         $error("walk setup supports a 64-bit address and four levels");
      end
   endgenerate

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid &&
         $stable({out_sel_hi, out_gran, out_in_size, out_level, out_out_size, out_fault, out_cause})));

   a_r2_narrow_gran: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !in_mode64) |=> (out_gran == 2'd0));

   a_r8_narrow_osize: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !in_mode64) |=> (out_out_size == SIZE_W'(NARROW_OUT)));

   a_r4_insize_window: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_fault) |-> ((out_in_size >= SIZE_W'(MIN_IN)) && (out_in_size <= SIZE_W'(PA_MAX))));

   a_r7_big_grain_level: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_fault && out_gran == 2'd2) |-> (out_level != 2'd0));

endmodule

// File: tb/tb_wsd_walk_setup.sv
`timescale 1ns/1ps
module tb_wsd_walk_setup;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_ctrl = '0;
   logic [63:0] in_base_lo = '0, in_base_hi = '0, in_va = '0;
   logic        in_mode64 = 1'b1;
   logic        out_valid, out_ready = 1'b1;
   logic        out_sel_hi, out_fault;
   logic [1:0]  out_gran, out_level, out_cause;
   logic [6:0]  out_in_size, out_out_size;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   wsd_walk_setup dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_ctrl(in_ctrl), .in_base_lo(in_base_lo), .in_base_hi(in_base_hi),
      .in_mode64(in_mode64), .in_va(in_va), .out_valid(out_valid), .out_ready(out_ready),
      .out_sel_hi(out_sel_hi), .out_gran(out_gran), .out_in_size(out_in_size),
      .out_level(out_level), .out_out_size(out_out_size), .out_fault(out_fault),
      .out_cause(out_cause)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_ctrl(input int szl, input int szh, input int gl, input int gh,
                                            input int dl, input int dh, input int tl, input int th,
                                            input int ps);
      logic [31:0] c;
      c = '0;
      c[5:0]   = 6'(szl);
      c[13:8]  = 6'(szh);
      c[17:16] = 2'(gl);
      c[19:18] = 2'(gh);
      c[20]    = 1'(dl);
      c[21]    = 1'(dh);
      c[22]    = 1'(tl);
      c[23]    = 1'(th);
      c[26:24] = 3'(ps);
      return c;
   endfunction

   // expected-value model
   int e_sel, e_gran, e_in, e_lvl, e_osz, e_cause;

   task automatic model(input logic [31:0] c, input logic [63:0] bl, input logic [63:0] bh,
                        input bit m64, input logic [63:0] va);
      int szl, szh, gcode, g, sh, st, n, q, ps;
      bit off, none, insz_bad, ps_bad, base_bad;
      logic [63:0] base;
      szl = int'(c[5:0]); szh = int'(c[13:8]); ps = int'(c[26:24]);
      none = 0;
      if (m64) begin
         bit t55;
         t55   = (va[55] && c[23]) || (!va[55] && c[22]);
         e_sel = t55 ? int'(va[55]) : int'(va[63]);
         if (e_sel == 0) begin
            gcode = int'(c[17:16]);
            g = (gcode == 1) ? 2 : (gcode == 2) ? 1 : 0;
            e_in = 64 - szl; off = c[20];
         end else begin
            gcode = int'(c[19:18]);
            g = (gcode == 1) ? 1 : (gcode == 3) ? 2 : 0;
            e_in = 64 - szh; off = c[21];
         end
         case (ps)
            0: e_osz = 32; 1: e_osz = 36; 2: e_osz = 40;
            3: e_osz = 42; 4: e_osz = 44; default: e_osz = 48;
         endcase
         insz_bad = (e_in > 48) || (e_in < 25);
         ps_bad   = ps > 5;
      end else begin
         int s0, s1;
         bit lo, hi;
         s0 = szl % 8; s1 = szh % 8;
         lo = (s0 == 0) || ((va[31:0] >> (32 - s0)) == 0);
         hi = (s1 != 0 && ((va[31:0] >> (32 - s1)) == ((64'd1 << s1) - 1))) || (s1 == 0 && !lo);
         g = 0;
         if (hi)      begin e_sel = 1; e_in = 32 - s1; off = c[21]; end
         else if (lo) begin e_sel = 0; e_in = 32 - s0; off = c[20]; end
         else         begin e_sel = 0; e_in = 32 - s0; off = 1; none = 1; end
         e_osz = 40; insz_bad = 0; ps_bad = 0;
      end
      e_gran = g;
      sh = 12 + 2 * g; st = sh - 3; n = e_in - sh;
      q = (n + st - 1) / st;
      e_lvl = 4 - q;
      base = e_sel ? bh : bl;
      base_bad = (e_osz < 48) && (((base & 64'h0000_FFFF_FFFF_FFFF) >> e_osz) != 0);
      if (insz_bad)      e_cause = 1;
      else if (off)      e_cause = 2;
      else if (ps_bad)   e_cause = 1;
      else if (base_bad) e_cause = 3;
      else               e_cause = 0;
      if (none) e_cause = (e_cause == 0 || e_cause == 3) ? 2 : e_cause;
   endtask

   task automatic check_out(input bit m64);
      chk(out_valid === 1'b1, "R11 result valid", out_valid, 1);
      chk(out_sel_hi == 1'(e_sel), m64 ? "R3 region select" : "R5 narrow region select", out_sel_hi, e_sel);
      chk(out_gran == 2'(e_gran), m64 ? (e_sel ? "R2 high granule" : "R1 low granule") : "R2 narrow granule",
          out_gran, e_gran);
      chk(out_in_size == 7'(e_in), m64 ? "R4 input size" : "R5 input size", out_in_size, e_in);
      chk(out_cause == 2'(e_cause), "R10 fault cause (R6 R8 R9)", out_cause, e_cause);
      chk(out_fault == (e_cause != 0), "R12 fault flag", out_fault, e_cause != 0);
      if (e_cause == 0) begin
         chk(out_level == 2'(e_lvl), "R7 start level", out_level, e_lvl);
         chk(out_out_size == 7'(e_osz), "R8 output size", out_out_size, e_osz);
      end
   endtask

   task automatic run_one(input logic [31:0] c, input logic [63:0] bl, input logic [63:0] bh,
                          input bit m64, input logic [63:0] va);
      @(negedge clk);
      in_ctrl = c; in_base_lo = bl; in_base_hi = bh; in_mode64 = m64; in_va = va;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      model(c, bl, bh, m64, va);
      check_out(m64);
   endtask

   localparam logic [63:0] VA_PAT [4] = '{64'h0000_0000_1234_5000, 64'h0080_0000_0000_0000,
                                          64'h8000_0000_0000_0000, 64'hFF7F_FFFF_FFFF_F000};

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state, R11 ready while empty
      chk(out_valid == 1'b0, "R12 reset out_valid", out_valid, 0);
      chk(in_ready == 1'b1, "R11 ready while empty", in_ready, 1);
      rst_n = 1'b1;

      // sweep A: granule codes, tag-ignore, region bit, sizes (R1 R2 R3 R4 R7)
      foreach (VA_PAT[v]) begin
         for (int s = 0; s < 8; s++) begin
            int sz;
            sz = (s == 0) ? 0 : (s == 1) ? 15 : (s == 2) ? 16 : (s == 3) ? 20 :
                 (s == 4) ? 25 : (s == 5) ? 33 : (s == 6) ? 39 : 40;
            for (int gl = 0; gl < 4; gl++)
               for (int gh = 0; gh < 4; gh++)
                  for (int t = 0; t < 4; t++)
                     run_one(mk_ctrl(sz, sz, gl, gh, 0, 0, t & 1, t >> 1, 5), 64'h1000, 64'h2000, 1'b1, VA_PAT[v]);
         end
      end

      // sweep B: disables, physical codes, base range and their ranking (R6 R8 R9 R10)
      for (int sv = 0; sv < 3; sv++)
         for (int d = 0; d < 4; d++)
            for (int ps = 0; ps < 8; ps++)
               for (int b = 0; b < 5; b++)
                  for (int v = 0; v < 2; v++) begin
                     logic [63:0] bv;
                     int sz;
                     sz = (sv == 0) ? 16 : (sv == 1) ? 10 : 28;
                     bv = (b == 0) ? 64'h0 : (b == 1) ? (64'd1 << 33) : (b == 2) ? (64'd1 << 41) :
                          (b == 3) ? (64'd1 << 47) : 64'hFFF0_0000_0000_0000;
                     run_one(mk_ctrl(sz, sz, 0, 2, d & 1, d >> 1, 0, 0, ps), bv, bv ^ 64'h3000,
                             1'b1, (v == 0) ? 64'h0 : 64'hFFFF_FFFF_FFFF_0000);
                  end

      // sweep C: 32-bit regime split rules (R5 R6 R2 R8), code field ignored
      for (int s0 = 0; s0 < 8; s0++)
         for (int s1 = 0; s1 < 8; s1++)
            for (int v = 0; v < 6; v++)
               for (int d = 0; d < 4; d++) begin
                  logic [63:0] va;
                  va = (v == 0) ? 64'h0000_1000 : (v == 1) ? 64'hFFFF_F000 : (v == 2) ? 64'h8000_0000 :
                       (v == 3) ? 64'h0400_0000 : (v == 4) ? 64'hF000_0000 : 64'hFE00_0000;
                  run_one(mk_ctrl(s0 + 8 * (v % 2), s1, 1, 3, d & 1, d >> 1, 1, 1, 7),
                          64'h0000_00F0_0000_0000, 64'h0000_0000_4000_0000, 1'b0, va);
               end

      // handshake stall with a second request offered (R11)
      begin
         logic [31:0] ca, cb;
         ca = mk_ctrl(16, 16, 0, 0, 0, 0, 0, 0, 5);
         cb = mk_ctrl(34, 34, 2, 1, 0, 0, 0, 0, 5);
         @(negedge clk);
         out_ready = 1'b0;
         in_ctrl = ca; in_base_lo = 64'h1000; in_base_hi = 64'h1000; in_mode64 = 1'b1; in_va = 64'h0;
         in_valid = 1'b1;
         @(negedge clk);
         in_ctrl = cb;
         for (int k = 0; k < 3; k++) begin
            chk(in_ready == 1'b0, "R11 not ready while stalled", in_ready, 0);
            chk(out_valid == 1'b1 && out_in_size == 7'd48 && out_level == 2'd0,
                "R11 held result unchanged", out_in_size, 48);
            @(negedge clk);
         end
         out_ready = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         chk(out_valid == 1'b1 && out_in_size == 7'd30 && out_gran == 2'd1,
             "R11 new request taken on accept", out_in_size, 30);
         chk(out_level == 2'd2, "R11 R7 level of second request", out_level, 2);
         @(negedge clk);
         chk(out_valid == 1'b0, "R11 empty after accept", out_valid, 0);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule